// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits between the CPU and picture buses of an 8-bit console and the memories on a game cartridge. It turns bus addresses into physical program-ROM and pattern-memory (CHR) addresses. It also decodes the battery-backed work RAM window and reports a two-bit nametable mirroring code to the picture side. The CPU programs the block one bit at a time. Each write in the range 0x8000–0xFFFF feeds data bit 0 into a five-bit shift register. The fifth such write commits the assembled value into one of four internal registers, and that write's address picks which one.

A control register sets the mirroring and selects the layouts. CHR is either one 8 KiB window or two 4 KiB windows. Program ROM is either one 32 KiB window, a fixed-low/switched-high pair of 16 KiB windows, or a switched-low/fixed-high pair. Two parameters give the number of 16 KiB program banks and 8 KiB CHR banks. Every bank number is reduced modulo what exists. The memory arrays are outside the block. Physical addresses are combinational from the current registers and the bus addresses.

Top module: `serial_bank_ctrl`

## Requirements
- R1: The shift register resets to 5'b10000. Each CPU write with cpu_addr[15]=1 and cpu_data[7]=0 moves data bit 0 into shift bit 4 and moves the other bits down one place, so the value is sent least significant bit first over five writes.
- R2: A write that finds shift bit 0 set before the shift commits the shifted five-bit value and re-arms the shift register to 5'b10000. Writes with cpu_addr[15]=0 do not touch the shift register.
- R3: A write with cpu_addr[15]=1 and cpu_data[7]=1 re-arms the shift register and ORs 0x0C into the control register. It commits nothing else.
- R4: cpu_addr[14:13] of the committing write picks the target: 0 control, 1 CHR bank A, 2 CHR bank B, 3 program bank.
- R5: The mirror output equals control bits 1:0. The codes are 0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal.
- R6: With control bit 4 at 0, CHR is one 8 KiB window. ppu_addr[12]=0 selects 4 KiB page (A & ~1) mod 2·CHR_BANKS, and ppu_addr[12]=1 selects the next page. A commit to CHR bank B is ignored in this mode.
- R7: With control bit 4 at 1, ppu_addr[12]=0 uses page A mod 2·CHR_BANKS and ppu_addr[12]=1 uses page B mod 2·CHR_BANKS. chr_addr is {page, ppu_addr[11:0]}.
- R8: Control bits 3:2 select the program layout. In modes 0 and 1 the low window is bank (P & ~1) mod PRG_BANKS and the high window is the next bank. In mode 2 the low window is bank 0 and the high window is P mod PRG_BANKS. In mode 3 the low window is P mod PRG_BANKS and the high window is bank PRG_BANKS−1. cpu_addr[14] picks the window, and prg_addr is {bank, cpu_addr[13:0]}.
- R9: Only the low four bits of the committed value are kept as the program bank P.
- R10: sram_sel is 1 exactly when cpu_addr is in 0x6000–0x7FFF.
- R11: After reset the control register is 0, so program banks 0 and 1 and CHR pages 0 and 1 are visible and mirror is 0.
- R12: A commit takes effect on the clock edge of the fifth write. Before that edge the outputs reflect the old registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Picture-bus pattern-memory address |
| prg_addr | output | PRG_AW | Physical program-ROM address |
| chr_addr | output | CHR_AW | Physical CHR memory address |
| sram_sel | output | 1 | Work RAM window select |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that cpu_we is a single-cycle pulse per bus write, and that cpu_addr and cpu_data are steady while it is high. They also assume PRG_BANKS is even, so the bank after an even 32 KiB base exists. The bench drives every write for exactly one cycle, changing inputs only on the falling edge. It keeps the parameters at their even defaults. Program-bank values above the bank count are used on purpose to exercise the modulo and the dropping of bit 4.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_CHRA = 2'd1,
        TGT_CHRB = 2'd2,
        TGT_PRG  = 2'd3
    } target_e;

    localparam logic [4:0] SHIFT_EMPTY = 5'b10000;

    typedef struct packed {
        logic [4:0] ctrl;
        logic [4:0] chra;
        logic [4:0] chrb;
        logic [3:0] prg;
    } bank_regs_t;

endpackage

// File: rtl/serial_loader.sv
module serial_loader
    import serial_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] wr_sel,
    output logic       commit,
    output logic [4:0] commit_val,
    output target_e    commit_tgt,
    output logic       clear
);

    typedef struct packed {
        logic [4:0] shift;
    } loader_t;

    loader_t st_q, st_d;
    logic [4:0] shifted;

    always_comb begin
        st_d       = st_q;
        shifted    = {wr_data[0], st_q.shift[4:1]};
        commit     = 1'b0;
        clear      = 1'b0;
        commit_val = shifted;
        commit_tgt = target_e'(wr_sel);
        if (wr_en) begin
            if (wr_data[7]) begin
                clear      = 1'b1;
                st_d.shift = SHIFT_EMPTY;
            end else if (st_q.shift[0]) begin
                commit     = 1'b1;
                st_d.shift = SHIFT_EMPTY;
            end else begin
                st_d.shift = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{shift: SHIFT_EMPTY};
        else        st_q <= st_d;
    end

    assert_rearm_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> st_q.shift == SHIFT_EMPTY);

    assert_rearm_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.shift == SHIFT_EMPTY);

    assert_idle_keeps_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.shift));

    assert_commit_clear_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, clear}));

endmodule

// File: rtl/bank_file.sv
module bank_file
    import serial_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic [4:0] commit_val,
    input  target_e    commit_tgt,
    input  logic       clear,
    output bank_regs_t regs
);

    bank_regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (clear) begin
            regs_d.ctrl = regs_q.ctrl | 5'h0C;
        end else if (commit) begin
            unique case (commit_tgt)
                TGT_CTRL: regs_d.ctrl = commit_val;
                TGT_CHRA: regs_d.chra = commit_val;
                TGT_CHRB: if (regs_q.ctrl[4]) regs_d.chrb = commit_val;
                TGT_PRG:  regs_d.prg  = commit_val[3:0];
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_clear_forces_mode3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> regs_q.ctrl[3:2] == 2'b11);

    assert_clear_keeps_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> $stable(regs_q.chra) && $stable(regs_q.chrb) && $stable(regs_q.prg));

    assert_chrb_ignored_8k_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_tgt == TGT_CHRB && !regs_q.ctrl[4]) |=> $stable(regs_q.chrb));

    assert_prg_commit_low4_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_tgt == TGT_PRG) |=> regs_q.prg == $past(commit_val[3:0]));

endmodule

// File: rtl/addr_map.sv
module addr_map
    import serial_bank_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 4,
    localparam int PRG_BW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CHR_PAGES = 2 * CHR_BANKS,
    localparam int CHR_PW = $clog2(CHR_PAGES),
    localparam int PRG_AW = PRG_BW + 14,
    localparam int CHR_AW = CHR_PW + 12
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_regs_t        regs,
    input  logic [15:0]       cpu_addr,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              sram_sel,
    output logic [1:0]        mirror
);

    localparam int unsigned PRG_LAST = PRG_BANKS - 1;

    logic [31:0] prg_sel32, chr_sel32;
    logic [31:0] prg_even, prg_mod, chra_even, chra_mod, chrb_mod;
    logic [PRG_BW-1:0] prg_bank;
    logic [CHR_PW-1:0] chr_page;

    always_comb begin
        prg_even  = ({28'd0, regs.prg} & 32'hE) % PRG_BANKS;
        prg_mod   = {28'd0, regs.prg} % PRG_BANKS;
        chra_even = ({27'd0, regs.chra} & 32'h1E) % CHR_PAGES;
        chra_mod  = {27'd0, regs.chra} % CHR_PAGES;
        chrb_mod  = {27'd0, regs.chrb} % CHR_PAGES;

        unique case (regs.ctrl[3:2])
            2'd2:    prg_sel32 = cpu_addr[14] ? prg_mod : 32'd0;
            2'd3:    prg_sel32 = cpu_addr[14] ? PRG_LAST : prg_mod;
            default: prg_sel32 = prg_even + {31'd0, cpu_addr[14]};
        endcase

        if (regs.ctrl[4]) chr_sel32 = ppu_addr[12] ? chrb_mod : chra_mod;
        else              chr_sel32 = chra_even + {31'd0, ppu_addr[12]};

        prg_bank = prg_sel32[PRG_BW-1:0];
        chr_page = chr_sel32[CHR_PW-1:0];
    end

    assign prg_addr = {prg_bank, cpu_addr[13:0]};
    assign chr_addr = {chr_page, ppu_addr[11:0]};
    assign sram_sel = (cpu_addr[15:13] == 3'b011);
    assign mirror   = regs.ctrl[1:0];

    assert_mode2_low_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[3:2] == 2'd2 && !cpu_addr[14]) |-> prg_addr[PRG_AW-1:14] == '0);

    assert_mode3_high_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[3:2] == 2'd3 && cpu_addr[14]) |-> prg_addr[PRG_AW-1:14] == PRG_BW'(PRG_LAST));

    assert_prg_offset_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[13:0] == cpu_addr[13:0]);

    assert_chr8k_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.ctrl[4] |-> chr_addr[12] == ppu_addr[12]);

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import serial_bank_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 4,
    localparam int PRG_BW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CHR_PW = $clog2(2 * CHR_BANKS),
    localparam int PRG_AW = PRG_BW + 14,
    localparam int CHR_AW = CHR_PW + 12
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_data,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              sram_sel,
    output logic [1:0]        mirror
);

    logic       ld_commit, ld_clear;
    logic [4:0] ld_val;
    target_e    ld_tgt;
    bank_regs_t regs;

    serial_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_we && cpu_addr[15]),
        .wr_data    (cpu_data),
        .wr_sel     (cpu_addr[14:13]),
        .commit     (ld_commit),
        .commit_val (ld_val),
        .commit_tgt (ld_tgt),
        .clear      (ld_clear)
    );

    bank_file u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (ld_commit),
        .commit_val (ld_val),
        .commit_tgt (ld_tgt),
        .clear      (ld_clear),
        .regs       (regs)
    );

    addr_map #(
        .PRG_BANKS (PRG_BANKS),
        .CHR_BANKS (CHR_BANKS)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .regs     (regs),
        .cpu_addr (cpu_addr),
        .ppu_addr (ppu_addr),
        .prg_addr (prg_addr),
        .chr_addr (chr_addr),
        .sram_sel (sram_sel),
        .mirror   (mirror)
    );

    assert_low_write_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cpu_addr[15]) |=> $stable(regs));

endmodule

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb_top;

    localparam int PRG_AW = 17;
    localparam int CHR_AW = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic              cpu_we = 1'b0;
    logic [7:0]        cpu_data = 8'h00;
    logic [12:0]       ppu_addr = 13'h0000;
    logic [PRG_AW-1:0] prg_addr;
    logic [CHR_AW-1:0] chr_addr;
    logic              sram_sel;
    logic [1:0]        mirror;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_bank_ctrl #(.PRG_BANKS(8), .CHR_BANKS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .sram_sel(sram_sel), .mirror(mirror)
    );

    // {ctrl[4:0], prg[4:0], cpu_addr[15:0], expected bank[2:0]}
    localparam logic [28:0] VEC [8] = '{
        {5'h00, 5'h05, 16'h8123, 3'd4},
        {5'h00, 5'h05, 16'hC456, 3'd5},
        {5'h08, 5'h05, 16'h8001, 3'd0},
        {5'h08, 5'h05, 16'hC002, 3'd5},
        {5'h0C, 5'h06, 16'h8ABC, 3'd6},
        {5'h0C, 5'h06, 16'hFFFF, 3'd7},
        {5'h0C, 5'h1B, 16'h8010, 3'd3},
        {5'h04, 5'h0F, 16'hC020, 3'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_we   = 1'b1;
        @(negedge clk);
        cpu_we   = 1'b0;
    endtask

    task automatic load_reg(input logic [1:0] tgt, input logic [4:0] val);
        for (int i = 0; i < 5; i++)
            cpu_wr({1'b1, tgt, 13'h0}, {7'd0, val[i]});
    endtask

    task automatic prg_at(input logic [15:0] a, input int bank, input string req);
        cpu_addr = a;
        #1;
        check(req, int'(prg_addr), (bank << 14) | int'(a[13:0]));
    endtask

    task automatic chr_at(input logic [12:0] a, input int page, input string req);
        ppu_addr = a;
        #1;
        check(req, int'(chr_addr), (page << 12) | int'(a[11:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 power-on state
        check("R11 mirror", int'(mirror), 0);
        prg_at(16'h8000, 0, "R11 prg low");
        prg_at(16'hC000, 1, "R11 prg high");
        chr_at(13'h0000, 0, "R11 chr low");
        chr_at(13'h1000, 1, "R11 chr high");

        // R8 R9 R4 vector table
        foreach (VEC[k]) begin
            load_reg(2'd0, VEC[k][28:24]);
            load_reg(2'd3, VEC[k][23:19]);
            prg_at(VEC[k][18:3], int'(VEC[k][2:0]), $sformatf("R8/R9 vec%0d", k));
        end

        // R5 mirror codes
        load_reg(2'd0, 5'h02);
        check("R5 vertical", int'(mirror), 2);
        load_reg(2'd0, 5'h03);
        check("R5 horizontal", int'(mirror), 3);

        // R1 R12 timing: four writes change nothing, fifth edge applies
        for (int i = 0; i < 4; i++) cpu_wr(16'h8000, {7'd0, i == 0});
        check("R12 before fifth", int'(mirror), 3);
        cpu_wr(16'h8000, 8'h00);
        check("R1 R12 after fifth", int'(mirror), 1);

        // R2 low writes do not shift
        cpu_wr(16'h8000, 8'h00);
        cpu_wr(16'h8000, 8'h01);
        cpu_wr(16'h6000, 8'h01);
        cpu_wr(16'h1000, 8'h01);
        cpu_wr(16'h8000, 8'h00);
        check("R2 no early commit", int'(mirror), 1);
        cpu_wr(16'h8000, 8'h00);
        cpu_wr(16'h8000, 8'h00);
        check("R2 value 0x02", int'(mirror), 2);

        // R3 clear mid-load
        load_reg(2'd3, 5'h02);
        cpu_wr(16'hE000, 8'h01);
        cpu_wr(16'hE000, 8'h01);
        cpu_wr(16'hA000, 8'h80);
        check("R3 mirror kept", int'(mirror), 2);
        prg_at(16'h8000, 2, "R3 mode3 low");
        prg_at(16'hC000, 7, "R3 mode3 high");
        load_reg(2'd0, 5'h01);
        check("R3 rearmed", int'(mirror), 1);

        // R6 8 KiB CHR and ignored bank B write
        load_reg(2'd0, 5'h00);
        load_reg(2'd1, 5'h05);
        chr_at(13'h0010, 4, "R6 low page");
        chr_at(13'h1FFF, 5, "R6 high page");
        load_reg(2'd2, 5'h03);
        chr_at(13'h1000, 5, "R6 B write no effect");
        load_reg(2'd0, 5'h10);
        chr_at(13'h1000, 0, "R6 B kept reset value");

        // R7 4 KiB CHR modulo
        load_reg(2'd1, 5'h0B);
        load_reg(2'd2, 5'h1E);
        chr_at(13'h0ABC, 3, "R7 page A");
        chr_at(13'h1123, 6, "R7 page B");
        load_reg(2'd2, 5'h07);
        chr_at(13'h1000, 7, "R7 page B reload");
        chr_at(13'h0000, 3, "R4 A untouched");

        // R10 SRAM window
        cpu_addr = 16'h6000; #1 check("R10 0x6000", int'(sram_sel), 1);
        cpu_addr = 16'h7FFF; #1 check("R10 0x7FFF", int'(sram_sel), 1);
        cpu_addr = 16'h5FFF; #1 check("R10 0x5FFF", int'(sram_sel), 0);
        cpu_addr = 16'h8000; #1 check("R10 0x8000", int'(sram_sel), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule